// File: doc/BRIEF.md
# Prioritized Three-Buffer Transmit Scheduler

This block decides which of three CAN transmit buffers goes on the bus next. Software marks a buffer as pending with a request pulse. It gives each buffer a 2-bit priority and a per-buffer interrupt enable. When the bus goes free, the scheduler makes its choice in that same cycle. It raises a one-cycle start strobe towards the frame engine and presents the chosen buffer's index. After that it waits for the engine's done pulse and the result code, and then updates the buffer's request bit and its status flags.

A failed attempt leaves the request set, so the buffer is tried again at the next free bus. Losing arbitration is silent: no interrupt is raised. Software can withdraw one buffer, or it can raise a global abort that withdraws every pending buffer. A buffer that is already on the bus is not withdrawn at once. It stays in flight, and the abort applies only if that attempt fails. The global abort bit clears itself once nothing remains in flight.

Top module: `can_tx_sched`

## Requirements
- R1: When no attempt is in progress, `bus_idle` is high, at least one request is set and the global abort bit is clear, `eng_start` is high for that cycle. `eng_idx` then carries the pending buffer with the largest priority value (3 highest, 0 lowest). When priorities are equal, the higher buffer index wins.
- R2: Priority is read in the start cycle itself, so a change made after the request was set but before the bus goes free decides the choice.
- R3: A `req_set` pulse sets that buffer's request bit and clears its abort, lost-arbitration and error flags in the next cycle.
- R4: A result of 00 (success) clears the in-flight buffer's request. The buffer's `txif` bit is set only if its `irq_en` bit is high.
- R5: A result of 01 (lost arbitration) sets the buffer's lost-arbitration flag. The request stays set and no `txif` bit is set.
- R6: A result of 10 or 11 (error) sets the buffer's error flag, and the request stays set.
- R7: A `req_clr` pulse on a pending buffer that is not in flight clears its request and sets its abort flag. The buffer is then never started and sets no `txif` bit.
- R8: If `req_clr` hits the in-flight buffer, its request stays set until the done pulse. A failing result then clears the request and sets the abort flag as well as the result flag, with no `txif`.
- R9: If `req_clr` hits the in-flight buffer and the attempt succeeds, the outcome is the plain success of R4, and the abort flag stays clear.
- R10: An `abort_all` pulse sets `abort_all_q` in the next cycle. While that bit is set, no attempt starts, and every pending buffer that is not in flight is aborted in the following cycle. The in-flight buffer is handled as in R8 and R9. The bit clears in the first cycle in which no attempt is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 3 | Per-buffer request pulse |
| req_clr | input | 3 | Per-buffer abort pulse |
| prio | input | 6 | Priorities, buffer i in bits [2i+1:2i] |
| irq_en | input | 3 | Per-buffer transmit interrupt enable |
| txif_clr | input | 3 | Per-buffer interrupt flag clear |
| abort_all | input | 1 | Global abort pulse |
| bus_idle | input | 1 | Bus free, start of frame allowed |
| eng_done | input | 1 | Frame engine finished the attempt |
| eng_result | input | 2 | 00 success, 01 lost arbitration, 1x error |
| eng_start | output | 1 | Start strobe to the frame engine |
| eng_idx | output | 2 | Buffer chosen for the attempt |
| req_q | output | 3 | Request bits |
| abt_q | output | 3 | Abort flags |
| larb_q | output | 3 | Lost-arbitration flags |
| err_q | output | 3 | Error flags |
| txif | output | 3 | Transmit interrupt flags |
| abort_all_q | output | 1 | Global abort in progress |

## Verification
A wrong winner shows up at once: the next start strobe carries the wrong index. The scoreboard catches this in the cycle the bus is offered. If the scheduler lost track of the in-flight buffer, a result would be applied to the wrong buffer. The flags and request bits would then be wrong in the cycle right after the done pulse. A late abort handled the wrong way shows in that same cycle, as an abort flag, request bit or interrupt flag that does not match. A global abort bit that stays stuck blocks every later start, so the next scoreboard item is never consumed.

// File: rtl/can_tx_sched.sv
module can_tx_sched (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_set,
  input  logic [2:0] req_clr,
  input  logic [5:0] prio,
  input  logic [2:0] irq_en,
  input  logic [2:0] txif_clr,
  input  logic       abort_all,
  input  logic       bus_idle,
  input  logic       eng_done,
  input  logic [1:0] eng_result,
  output logic       eng_start,
  output logic [1:0] eng_idx,
  output logic [2:0] req_q,
  output logic [2:0] abt_q,
  output logic [2:0] larb_q,
  output logic [2:0] err_q,
  output logic [2:0] txif,
  output logic       abort_all_q
);

  logic       busy;
  logic [1:0] cur;
  logic [2:0] kill;
  logic [1:0] best;
  logic       found;

  always_comb begin
    eng_idx = 2'd0;
    best    = 2'd0;
    found   = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (req_q[i] && (!found || prio[2*i +: 2] >= best)) begin
        eng_idx = 2'(i);
        best    = prio[2*i +: 2];
        found   = 1'b1;
      end
    end
  end

  assign eng_start = !busy && bus_idle && found && !abort_all_q;

  wire finish = busy && eng_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur         <= 2'd0;
      abort_all_q <= 1'b0;
    end else begin
      if (eng_start) begin
        busy <= 1'b1;
        cur  <= eng_idx;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (abort_all)
        abort_all_q <= 1'b1;
      else if (abort_all_q && !busy)
        abort_all_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      abt_q  <= '0;
      larb_q <= '0;
      err_q  <= '0;
      txif   <= '0;
      kill   <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (req_q[i] && !(busy && cur == 2'(i))) begin
          if (abort_all_q || req_clr[i]) begin
            req_q[i] <= 1'b0;
            abt_q[i] <= 1'b1;
          end
        end
        if (req_clr[i] && busy && cur == 2'(i))
          kill[i] <= 1'b1;
        if (finish && cur == 2'(i)) begin
          kill[i] <= 1'b0;
          if (eng_result == 2'b00) begin
            req_q[i] <= 1'b0;
            if (irq_en[i]) txif[i] <= 1'b1;
          end else begin
            if (eng_result == 2'b01) larb_q[i] <= 1'b1;
            else                     err_q[i]  <= 1'b1;
            if (kill[i] || req_clr[i] || abort_all_q) begin
              req_q[i] <= 1'b0;
              abt_q[i] <= 1'b1;
            end
          end
        end
        if (txif_clr[i]) txif[i] <= 1'b0;
        if (req_set[i]) begin
          req_q[i]  <= 1'b1;
          abt_q[i]  <= 1'b0;
          larb_q[i] <= 1'b0;
          err_q[i]  <= 1'b0;
          kill[i]   <= 1'b0;
        end
      end
    end
  end

endmodule

module can_tx_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic [1:0] eng_idx,
  input logic [5:0] prio,
  input logic [2:0] req_q,
  input logic [2:0] req_set,
  input logic       eng_done,
  input logic [1:0] eng_result,
  input logic [2:0] txif,
  input logic [2:0] abt_q,
  input logic [2:0] larb_q,
  input logic [2:0] err_q,
  input logic       busy,
  input logic [1:0] cur
);

  assert_start_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> req_q[eng_idx]);

  for (genvar j = 0; j < 3; j++) begin : g_win
    assert_winner_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && req_q[j]) |-> (prio[2*j +: 2] <= prio[2*eng_idx +: 2]));
  end

  assert_set_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_set) |=> (((req_q & $past(req_set)) == $past(req_set)) &&
                    (((abt_q | larb_q | err_q) & $past(req_set)) == 3'b000)));

  assert_success_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_result == 2'b00 && !req_set[cur]) |=> !req_q[$past(cur)]);

  assert_lost_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_result != 2'b00) |=> ((txif & ~$past(txif)) == 3'b000));

  assert_error_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_result[1] && !req_set[cur]) |=> err_q[$past(cur)]);

endmodule

bind can_tx_sched can_tx_sched_chk u_chk (.*);

// File: tb/tb_can_tx_sched.sv
`timescale 1ns/100ps
module tb_can_tx_sched;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] req_set = 0, req_clr = 0, irq_en = 0, txif_clr = 0;
  logic [5:0] prio = 0;
  logic       abort_all = 0, bus_idle = 0, eng_done = 0;
  logic [1:0] eng_result = 0;
  logic       eng_start, abort_all_q;
  logic [1:0] eng_idx;
  logic [2:0] req_q, abt_q, larb_q, err_q, txif;

  int checks = 0, failures = 0;
  logic [1:0] expq[$];

  always #2 clk = ~clk;

  can_tx_sched dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic pulse_set(input logic [2:0] m);
    req_set = m; step; req_set = 0;
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    req_clr = m; step; req_clr = 0;
  endtask

  task automatic pulse_txclr;
    txif_clr = 3'b111; step; txif_clr = 0;
  endtask

  task automatic start_frame(input logic [1:0] idx);
    expq.push_back(idx);
    bus_idle = 1; step; bus_idle = 0;
  endtask

  task automatic end_frame(input logic [1:0] res);
    eng_done = 1; eng_result = res; step; eng_done = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && eng_start) begin
      if (expq.size() == 0) chk("R1 unexpected start", eng_idx, 99);
      else chk("R1 start index", eng_idx, expq.pop_front());
    end
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step; step; rst_n = 1; step;
    chk("reset req", req_q, 0);
    chk("reset flags", {abt_q, larb_q, err_q, txif}, 0);
    chk("reset start", eng_start, 0);

    irq_en = 3'b111;
    prio = {2'd2, 2'd1, 2'd3};
    pulse_set(3'b111);
    start_frame(0); end_frame(2'b00);
    chk("R4 req after success", req_q, 3'b110);
    chk("R4 txif after success", txif, 3'b001);
    start_frame(2); end_frame(2'b00);
    start_frame(1); end_frame(2'b00);
    chk("R4 all sent", req_q, 0);
    chk("R4 txif all", txif, 3'b111);

    pulse_txclr;
    irq_en = 3'b110;
    prio = 6'b101010;
    pulse_set(3'b011);
    start_frame(1); end_frame(2'b00);
    start_frame(0); end_frame(2'b00);
    chk("R4 txif gated by enable", txif, 3'b010);
    chk("R1 tie done", req_q, 0);

    pulse_txclr;
    prio = 6'b010000;
    pulse_set(3'b101);
    prio = 6'b010011;
    step;
    start_frame(0); end_frame(2'b00);
    chk("R2 late priority", req_q, 3'b100);
    start_frame(2); end_frame(2'b01);
    chk("R5 larb", larb_q, 3'b100);
    chk("R5 req stays", req_q, 3'b100);
    chk("R5 no txif", txif, 0);
    start_frame(2); end_frame(2'b10);
    chk("R6 err", err_q, 3'b100);
    chk("R6 req stays", req_q, 3'b100);
    pulse_set(3'b100);
    chk("R3 flags cleared", {larb_q, err_q, abt_q}, 0);
    chk("R3 req set", req_q, 3'b100);
    start_frame(2); end_frame(2'b00);
    chk("R4 retry success", req_q, 0);

    irq_en = 3'b111;
    pulse_txclr;
    pulse_set(3'b010);
    pulse_clr(3'b010);
    chk("R7 req cleared", req_q, 0);
    chk("R7 abort flag", abt_q, 3'b010);
    bus_idle = 1;
    @(negedge clk);
    chk("R7 no start", eng_start, 0);
    step; bus_idle = 0;
    chk("R7 no txif", txif, 0);

    pulse_set(3'b001);
    start_frame(0);
    pulse_clr(3'b001);
    chk("R8 in flight kept", req_q, 3'b001);
    end_frame(2'b01);
    chk("R8 req", req_q, 0);
    chk("R8 abt", abt_q, 3'b011);
    chk("R8 larb", larb_q, 3'b001);
    chk("R8 txif", txif, 0);

    pulse_set(3'b001);
    start_frame(0);
    pulse_clr(3'b001);
    end_frame(2'b00);
    chk("R9 req", req_q, 0);
    chk("R9 abt", abt_q, 3'b010);
    chk("R9 txif", txif, 3'b001);

    pulse_txclr;
    pulse_set(3'b111);
    start_frame(0);
    abort_all = 1; step; abort_all = 0;
    chk("R10 bit set", abort_all_q, 1);
    step;
    chk("R10 others aborted", req_q, 3'b001);
    chk("R10 others abt", abt_q, 3'b110);
    end_frame(2'b10);
    chk("R10 in flight aborted", req_q, 0);
    chk("R10 abt all", abt_q, 3'b111);
    chk("R10 err", err_q, 3'b001);
    step;
    chk("R10 self clear", abort_all_q, 0);
    chk("R10 no txif", txif, 0);

    pulse_set(3'b110);
    abort_all = 1; step; abort_all = 0;
    chk("R10 idle pending held", req_q, 3'b110);
    step;
    chk("R10 idle aborted", req_q, 0);
    chk("R10 idle clear", abort_all_q, 0);
    chk("R10 idle abt", abt_q, 3'b111);

    step; step;
    chk("R1 scoreboard drained", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule